// File: doc/BRIEF.md
# Pulse Swallow Feedback and Reference Divider

This block provides the two digital dividers of an integer-N frequency synthesizer. A dual-modulus prescaler outside the block divides the oscillator output by P or by P+1 and supplies the prescaler clock. The block counts that clock with a main counter loaded with N. It also runs a swallow counter loaded with A, and it holds the modulus request high while the swallow counter is nonzero. Across one comparison period, the prescaler therefore divides by P+1 for A of its output cycles and by P for the remaining N−A cycles. The total division from the oscillator to the comparison pulse is P·N+A.

A second counter, clocked by the reference oscillator, divides by R and produces the reference comparison pulse. A selection input chooses between the 32/33 and 64/65 prescaler pairs. The chosen pair is passed on to the prescaler. Ratio inputs and the pair choice take effect only when a counter reloads, so a comparison period is never split between two settings.

Top module: `psd_divider`

## Requirements
- R1: `fp_pulse` is high for exactly one `pclk` cycle per period, and the period lasts N_eff `pclk` cycles.
- R2: `mod_hi` is high for the first A_eff `pclk` cycles of each feedback period and low for the rest of it. In particular it is low in the cycle where `fp_pulse` is high.
- R3: When A ≥ N_eff, the swallow count is clamped to A_eff = N_eff − 1. Otherwise A_eff = A.
- R4: When N < 5, the main count is clamped to N_eff = 5. Otherwise N_eff = N.
- R5: `fr_pulse` is high for one `oclk` cycle per period, and the period lasts R_eff `oclk` cycles. R_eff is 5 when R < 5 and equals R otherwise.
- R6: A change to N, A, R or `pair_sel` in the middle of a period does not alter that period. It applies from the following period.
- R7: `pair_q` is 1 for the 32/33 pair and 0 for the 64/65 pair. It follows `pair_sel` sampled at the feedback reload, and it holds constant within a period.
- R8: While `rst_n` is low, `fp_pulse`, `fr_pulse` and `mod_hi` are low and both counters are cleared. After release, the first `fp_pulse` appears in the N_eff-th `pclk` cycle.
- R9: In a prescaler model that spends P+1 input cycles per `pclk` cycle while `mod_hi` is high and P otherwise, one feedback period covers P·N_eff + A_eff input cycles, with P = 32 or 64 taken from `pair_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Prescaler output clock |
| oclk | input | 1 | Reference oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| n_ratio | input | 11 | Main counter ratio N |
| a_ratio | input | 7 | Swallow counter ratio A |
| r_ratio | input | 14 | Reference divider ratio R |
| pair_sel | input | 1 | Prescaler pair select: 1 = 32/33, 0 = 64/65 |
| mod_hi | output | 1 | Modulus request: 1 asks the prescaler for P+1 |
| fp_pulse | output | 1 | Feedback comparison pulse |
| fr_pulse | output | 1 | Reference comparison pulse |
| pair_q | output | 1 | Prescaler pair currently in effect |

## Verification
The hardest case to reach is a settings change that lands inside a running period. The old ratios must finish their count, and the new ones must load exactly at the following terminal cycle. The bench waits for a pulse, lets the period run for a few cycles, and then changes N, A, R and the pair select together. It then measures that period and the next one against the old and new settings. The clamp rules are reached by sweeping N from 0 up and A past N, with both prescaler pairs.

// File: rtl/psd_pkg.sv
`timescale 1ns/1ps
package psd_pkg;
   typedef enum logic {
      PAIR_64_65 = 1'b0,
      PAIR_32_33 = 1'b1
   } pair_e;
endpackage

// File: rtl/psd_reload_cnt.sv
`timescale 1ns/1ps
// Down counter that reloads from a (clamped) ratio at its terminal count.
module psd_reload_cnt #(
   parameter int W        = 11,
   parameter int MIN      = 5,
   parameter bit CLAMP_EN = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] ratio,
   output logic [W-1:0] ratio_eff,
   output logic         reload,
   output logic         at_term
);
   localparam logic [W-1:0] MIN_V = W'(MIN);
   localparam logic [W-1:0] ONE_V = W'(1);

   logic [W-1:0] cnt;

   generate
      if (CLAMP_EN) begin : g_clamp
         assign ratio_eff = (ratio < MIN_V) ? MIN_V : ratio;
      end else begin : g_pass
         assign ratio_eff = ratio;
      end
   endgenerate

   assign at_term = (cnt == ONE_V);
   assign reload  = (cnt == '0) || at_term;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (reload) cnt <= ratio_eff;
      else             cnt <= cnt - ONE_V;
   end
endmodule

// File: rtl/psd_swallow.sv
`timescale 1ns/1ps
// Swallow counter: requests the high modulus while nonzero.
module psd_swallow #(
   parameter int AW = 7,
   parameter int NW = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reload,
   input  logic [AW-1:0] a_in,
   input  logic [NW-1:0] n_eff,
   output logic          mod_hi
);
   logic [AW-1:0] scnt;
   logic [AW-1:0] a_eff;
   logic [NW-1:0] a_ext;
   logic [NW-1:0] n_less;

   assign a_ext  = NW'(a_in);
   assign n_less = n_eff - NW'(1);
   assign a_eff  = (a_ext >= n_eff) ? n_less[AW-1:0] : a_in;
   assign mod_hi = (scnt != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      scnt <= '0;
      else if (reload) scnt <= a_eff;
      else if (mod_hi) scnt <= scnt - AW'(1);
   end
endmodule

// File: rtl/psd_divider.sv
`timescale 1ns/1ps
module psd_divider #(
   parameter int NW        = 11,
   parameter int AW        = 7,
   parameter int RW        = 14,
   parameter int MIN_RATIO = 5
) (
   input  logic          pclk,
   input  logic          oclk,
   input  logic          rst_n,
   input  logic [NW-1:0] n_ratio,
   input  logic [AW-1:0] a_ratio,
   input  logic [RW-1:0] r_ratio,
   input  logic          pair_sel,
   output logic          mod_hi,
   output logic          fp_pulse,
   output logic          fr_pulse,
   output logic          pair_q
);
   import psd_pkg::*;

   generate
      if (AW >= NW) begin : g_bad_aw
         initial $fatal(1, "AW must be narrower than NW");
      end
      if (MIN_RATIO < 2) begin : g_bad_min
         initial $fatal(1, "MIN_RATIO must be at least 2");
      end
      if ((MIN_RATIO >= (1 << NW)) || (MIN_RATIO >= (1 << RW))) begin : g_bad_w
         initial $fatal(1, "MIN_RATIO does not fit the ratio widths");
      end
   endgenerate

   logic [NW-1:0] n_eff;
   logic [RW-1:0] r_eff;
   logic          fb_reload;
   logic          rf_reload;
   pair_e         pair_r;

   psd_reload_cnt #(.W(NW), .MIN(MIN_RATIO), .CLAMP_EN(1'b1)) u_main (
      .clk(pclk), .rst_n(rst_n), .ratio(n_ratio), .ratio_eff(n_eff),
      .reload(fb_reload), .at_term(fp_pulse)
   );

   psd_swallow #(.AW(AW), .NW(NW)) u_swallow (
      .clk(pclk), .rst_n(rst_n), .reload(fb_reload), .a_in(a_ratio),
      .n_eff(n_eff), .mod_hi(mod_hi)
   );

   psd_reload_cnt #(.W(RW), .MIN(MIN_RATIO), .CLAMP_EN(1'b1)) u_ref (
      .clk(oclk), .rst_n(rst_n), .ratio(r_ratio), .ratio_eff(r_eff),
      .reload(rf_reload), .at_term(fr_pulse)
   );

   always_ff @(posedge pclk or negedge rst_n) begin
      if (!rst_n)         pair_r <= PAIR_64_65;
      else if (fb_reload) pair_r <= pair_e'(pair_sel);
   end

   assign pair_q = (pair_r == PAIR_32_33);

   logic unused_ok;
   assign unused_ok = ^{r_eff, rf_reload};
endmodule

// File: rtl/psd_divider_chk.sv
`timescale 1ns/1ps
module psd_divider_chk (
   input logic pclk,
   input logic oclk,
   input logic rst_n,
   input logic mod_hi,
   input logic fp_pulse,
   input logic fr_pulse,
   input logic pair_q,
   input logic fb_reload
);
   // R1: feedback pulse lasts a single cycle
   a_r1_fp_single: assert property (@(posedge pclk) disable iff (!rst_n)
      fp_pulse |=> !fp_pulse);

   // R2: swallow count is exhausted by the terminal cycle
   a_r2_mod_low_at_term: assert property (@(posedge pclk) disable iff (!rst_n)
      fp_pulse |-> !mod_hi);

   // R6: modulus request only starts at a reload
   a_r6_mod_rise_at_reload: assert property (@(posedge pclk) disable iff (!rst_n)
      $rose(mod_hi) |-> $past(fb_reload));

   // R7: pair held between reloads
   a_r7_pair_stable: assert property (@(posedge pclk) disable iff (!rst_n)
      !$past(fb_reload) |-> $stable(pair_q));

   // R5: reference pulse lasts a single cycle
   a_r5_fr_single: assert property (@(posedge oclk) disable iff (!rst_n)
      fr_pulse |=> !fr_pulse);

   // R8: outputs quiet under reset
   always_comb begin
      if (!rst_n) begin
         a_r8_reset_quiet: assert (!fp_pulse && !fr_pulse && !mod_hi);
      end
   end
endmodule

bind psd_divider psd_divider_chk u_chk (
   .pclk(pclk), .oclk(oclk), .rst_n(rst_n), .mod_hi(mod_hi),
   .fp_pulse(fp_pulse), .fr_pulse(fr_pulse), .pair_q(pair_q),
   .fb_reload(fb_reload)
);

// File: tb/tb_psd_divider.sv
`timescale 1ns/1ps
module tb_psd_divider;
   logic        pclk = 1'b0;
   logic        oclk = 1'b0;
   logic        rst_n = 1'b0;
   logic [10:0] n_ratio = 11'd7;
   logic [6:0]  a_ratio = 7'd0;
   logic [13:0] r_ratio = 14'd9;
   logic        pair_sel = 1'b0;
   logic        mod_hi, fp_pulse, fr_pulse, pair_q;

   int errs = 0;
   int checks = 0;

   always #2.5 pclk = ~pclk;
   always #3.5 oclk = ~oclk;

   psd_divider dut (
      .pclk(pclk), .oclk(oclk), .rst_n(rst_n), .n_ratio(n_ratio),
      .a_ratio(a_ratio), .r_ratio(r_ratio), .pair_sel(pair_sel),
      .mod_hi(mod_hi), .fp_pulse(fp_pulse), .fr_pulse(fr_pulse),
      .pair_q(pair_q)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_fp();
      for (int i = 0; i < 200; i++) begin
         if (fp_pulse) return;
         @(negedge pclk);
      end
      chk(1'b0, "R1 fp never seen", 0, 1);
   endtask

   task automatic wait_fr();
      for (int i = 0; i < 200; i++) begin
         if (fr_pulse) return;
         @(negedge oclk);
      end
      chk(1'b0, "R5 fr never seen", 0, 1);
   endtask

   // counts one feedback period after an fp cycle, ending with the next fp
   task automatic measure(output int len, output int hi, output int vco, output int pchg);
      int p0;
      len = 0; hi = 0; vco = 0; pchg = 0; p0 = -1;
      for (int i = 0; i < 100; i++) begin
         @(negedge pclk);
         len++;
         if (p0 < 0) p0 = int'(pair_q);
         else if (p0 != int'(pair_q)) pchg++;
         if (mod_hi) hi++;
         vco += pair_q ? (mod_hi ? 33 : 32) : (mod_hi ? 65 : 64);
         if (fp_pulse) break;
      end
   endtask

   task automatic measure_fr(output int len);
      len = 0;
      for (int i = 0; i < 100; i++) begin
         @(negedge oclk);
         len++;
         if (fr_pulse) break;
      end
   endtask

   initial begin
      #900000;
      errs++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      int len, hi, vco, pchg, cnt;
      // R8: reset state
      repeat (3) @(negedge pclk);
      chk(!fp_pulse, "R8 fp in reset", int'(fp_pulse), 0);
      chk(!fr_pulse, "R8 fr in reset", int'(fr_pulse), 0);
      chk(!mod_hi, "R8 mod_hi in reset", int'(mod_hi), 0);
      chk(!pair_q, "R8 pair_q in reset", int'(pair_q), 0);
      rst_n = 1'b1;
      cnt = 0;
      for (int i = 0; i < 50; i++) begin
         @(negedge pclk);
         cnt++;
         if (fp_pulse) break;
      end
      chk(cnt == 7, "R8 first fp after reset", cnt, 7);

      // R1 R2 R3 R4 R7 R9: sweep
      for (int p = 0; p < 2; p++) begin
         for (int n = 0; n <= 12; n++) begin
            for (int a = 0; a <= 13; a++) begin
               int ne, ae, pp;
               ne = (n < 5) ? 5 : n;
               ae = (a >= ne) ? ne - 1 : a;
               pp = p ? 32 : 64;
               @(negedge pclk);
               n_ratio = 11'(n); a_ratio = 7'(a); pair_sel = p[0];
               wait_fp();
               measure(len, hi, vco, pchg);
               chk(len == ne, (n < 5) ? "R4 clamped period" : "R1 period", len, ne);
               chk(hi == ae, (a >= ne) ? "R3 clamped swallow" : "R2 high cycles", hi, ae);
               chk(vco == pp * ne + ae, "R9 total division", vco, pp * ne + ae);
               chk(int'(pair_q) == p && pchg == 0, "R7 pair output", int'(pair_q), p);
            end
         end
      end

      // R6: mid-period change of N, A and pair
      @(negedge pclk);
      n_ratio = 11'd8; a_ratio = 7'd3; pair_sel = 1'b0;
      wait_fp();
      measure(len, hi, vco, pchg);
      wait_fp();
      repeat (2) @(negedge pclk);
      n_ratio = 11'd6; a_ratio = 7'd1; pair_sel = 1'b1;
      cnt = 2;
      hi = 0;
      pchg = 0;
      for (int i = 0; i < 50; i++) begin
         @(negedge pclk);
         cnt++;
         if (mod_hi) hi++;
         if (pair_q) pchg++;
         if (fp_pulse) break;
      end
      chk(cnt == 8, "R6 old period kept", cnt, 8);
      chk(hi == 1, "R6 old swallow kept", hi, 1);
      chk(pchg == 0, "R6 old pair kept", pchg, 0);
      measure(len, hi, vco, pchg);
      chk(len == 6, "R6 new period", len, 6);
      chk(hi == 1, "R6 new swallow", hi, 1);
      chk(vco == 32 * 6 + 1, "R6 new division", vco, 193);

      // R5: reference sweep
      for (int r = 0; r <= 20; r++) begin
         int re;
         re = (r < 5) ? 5 : r;
         @(negedge oclk);
         r_ratio = 14'(r);
         wait_fr();
         measure_fr(len);
         chk(len == re, "R5 reference period", len, re);
      end

      // R6: mid-period change of R
      @(negedge oclk);
      r_ratio = 14'd10;
      wait_fr();
      measure_fr(len);
      repeat (3) @(negedge oclk);
      r_ratio = 14'd6;
      measure_fr(len);
      chk(len + 3 == 10, "R6 old reference period kept", len + 3, 10);
      measure_fr(len);
      chk(len == 6, "R6 new reference period", len, 6);

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule